// File: doc/BRIEF.md
# Coarse Carrier Offset Estimator (Lagged Autocorrelation)

This block produces a first, coarse estimate of the carrier frequency offset in a burst receiver. During the periodic short preamble, each complex baseband sample is multiplied by the complex conjugate of the sample received one preamble period earlier. A run of these products is summed. Because the preamble repeats with that period, its modulation cancels in the product. The sum then points at an angle equal to the phase the offset builds up over one period.

An iterative vectoring rotator measures the angle of the sum as a fraction of a full turn. Dividing that angle by the lag gives the phase advance per sample. That value is the word a receive phase accumulator needs as its starting increment, and it must be loaded before symbol timing recovery is enabled. A start pulse opens a window. The block raises a one-cycle done strobe when the increment and the raw correlation sum are ready, and it holds both until the next estimate. The increment reports the measured rotation per sample. The downstream mixer applies its conjugate.

Top module: `cfo_coarse_est`

## Requirements
- R1: While rst_ni is low and after it is released, done_o is 0 and corr_re_o, corr_im_o and incr_o read 0 until the first done strobe.
- R2: The delay history advances only on valid_i. The partner of each sample is the sample taken LAG (16) valid strobes earlier. Positions not yet filled since reset count as zero.
- R3: For each sample z = i + jq (I in smp_i_i, Q in smp_q_i, two's complement) the product is z times the conjugate of the delayed sample. corr_re_o and corr_im_o carry the exact two's-complement sum of the WIN (32) products that follow start_i. A sample valid in the same cycle as start_i is the first of them.
- R4: Cycles with valid_i low add nothing to the sum and do not advance the window.
- R5: incr_o equals the angle of the sum, in units where 2^32 is a full turn, arithmetic-shifted right by log2(LAG). Its error is at most 2048 units in any quadrant, and on the negative real axis the angle reads as a half turn.
- R6: done_o is high for exactly one cycle, in the cycle after clock edge ITER+2 (18), counted from the edge that takes the WIN-th sample of the window.
- R7: A start_i pulse during accumulation or during the angle computation drops the estimate in progress (no done_o for it), clears the sum and opens a new window.
- R8: Samples after a window closes are not accumulated, and corr_re_o, corr_im_o and incr_o hold their values between done strobes.
- R9: Full-scale inputs, including -32768 on both rails for every sample, never overflow the 40-bit sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a new estimation window, aborts any in progress |
| valid_i | input | 1 | Sample strobe, one per sample at the elementary rate |
| smp_i_i | input | 16 | In-phase sample, signed |
| smp_q_i | input | 16 | Quadrature sample, signed |
| corr_re_o | output | 40 | Real part of the correlation sum, signed |
| corr_im_o | output | 40 | Imaginary part of the correlation sum, signed |
| incr_o | output | 32 | Phase increment per sample, signed, 2^32 per turn |
| done_o | output | 1 | One-cycle strobe: outputs updated |

## Verification
The bench builds the block with its defaults: a 16-sample lag, a 32-product window and 16 rotator iterations. With these values a short preamble-length run of tone samples fills the history, and one window ends in an 18-cycle angle phase. That puts a restart inside the rotation phase within a few cycles of stimulus. Tones at +0.3, -1.0, +2.5 and -2.8 radians per lag cover all four quadrants, including the half-turn pre-rotation. The partly empty history right after reset, strobe gaps and constant -32768 inputs reach the zero-fill rule, the strobe gating and the worst-case sum magnitude.

// File: rtl/cfo_pkg.sv
package cfo_pkg;
  localparam int unsigned PHASE_W = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_ACC, ST_LOAD, ST_ROT} cfo_state_e;

  // atan(2^-idx) in turn units, 2^32 per turn
  function automatic logic [PHASE_W-1:0] atan_turn(input int unsigned idx);
    case (idx)
      0:  return 32'd536870912;
      1:  return 32'd316933406;
      2:  return 32'd167458907;
      3:  return 32'd85004756;
      4:  return 32'd42667331;
      5:  return 32'd21354465;
      6:  return 32'd10680094;
      7:  return 32'd5340245;
      8:  return 32'd2670163;
      9:  return 32'd1335087;
      10: return 32'd667544;
      11: return 32'd333772;
      12: return 32'd166886;
      13: return 32'd83443;
      14: return 32'd41722;
      15: return 32'd20861;
      default: return 32'd683565276 >> idx;
    endcase
  endfunction
endpackage

// File: rtl/cfo_lag_line.sv
module cfo_lag_line #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic [W-1:0] q;
    logic [W-1:0] src;
    if (g == 0) begin : g_head
      assign src = din_i;
    end else begin : g_tail
      assign src = g_stage[g-1].q;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q <= '0;
      else if (shift_i) q <= src;
    end
  end

  assign dout_o = g_stage[DEPTH-1].q;
endmodule

// File: rtl/cfo_corr_acc.sv
module cfo_corr_acc #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              add_i,
  input  logic [DATA_W-1:0] cur_re_i,
  input  logic [DATA_W-1:0] cur_im_i,
  input  logic [DATA_W-1:0] old_re_i,
  input  logic [DATA_W-1:0] old_im_i,
  output logic [ACC_W-1:0]  acc_re_o,
  output logic [ACC_W-1:0]  acc_im_o
);
  localparam int PW = 2*DATA_W + 1;

  logic signed [PW-1:0] a_x, b_x, c_x, d_x;
  logic signed [PW-1:0] p_re, p_im;
  logic signed [ACC_W-1:0] base_re, base_im, nxt_re, nxt_im;

  assign a_x = PW'($signed(cur_re_i));
  assign b_x = PW'($signed(cur_im_i));
  assign c_x = PW'($signed(old_re_i));
  assign d_x = PW'($signed(old_im_i));

  // cur * conj(old)
  assign p_re = a_x * c_x + b_x * d_x;
  assign p_im = b_x * c_x - a_x * d_x;

  assign base_re = clear_i ? '0 : $signed(acc_re_o);
  assign base_im = clear_i ? '0 : $signed(acc_im_o);
  assign nxt_re  = base_re + ACC_W'(p_re);
  assign nxt_im  = base_im + ACC_W'(p_im);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_re_o <= '0;
      acc_im_o <= '0;
    end else if (add_i) begin
      acc_re_o <= nxt_re;
      acc_im_o <= nxt_im;
    end else if (clear_i) begin
      acc_re_o <= '0;
      acc_im_o <= '0;
    end
  end
endmodule

// File: rtl/cfo_cordic_vec.sv
module cfo_cordic_vec
  import cfo_pkg::*;
#(
  parameter int IN_W = 40,
  parameter int ITER = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               abort_i,
  input  logic [IN_W-1:0]    x_i,
  input  logic [IN_W-1:0]    y_i,
  output logic [PHASE_W-1:0] angle_o,
  output logic               busy_o,
  output logic               fin_o
);
  localparam int CW   = IN_W + 2;
  localparam int IT_W = (ITER > 2) ? $clog2(ITER) : 1;

  logic signed [CW-1:0] x_q, y_q, x_in, y_in, x_sh, y_sh;
  logic [PHASE_W-1:0]   z_q, step;
  logic [IT_W-1:0]      it_q;
  logic                 neg;

  assign x_in = {{2{x_i[IN_W-1]}}, x_i};
  assign y_in = {{2{y_i[IN_W-1]}}, y_i};
  assign neg  = x_in[CW-1];
  assign x_sh = x_q >>> it_q;
  assign y_sh = y_q >>> it_q;
  assign step = atan_turn(32'(it_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0; y_q <= '0; z_q <= '0; it_q <= '0;
      busy_o <= 1'b0; fin_o <= 1'b0;
    end else if (abort_i) begin
      busy_o <= 1'b0; fin_o <= 1'b0;
    end else if (start_i) begin
      // left half-plane: rotate by a half turn first
      x_q    <= neg ? -x_in : x_in;
      y_q    <= neg ? -y_in : y_in;
      z_q    <= neg ? {1'b1, {(PHASE_W-1){1'b0}}} : '0;
      it_q   <= '0;
      busy_o <= 1'b1;
      fin_o  <= 1'b0;
    end else if (busy_o) begin
      if (!y_q[CW-1]) begin
        x_q <= x_q + y_sh;
        y_q <= y_q - x_sh;
        z_q <= z_q + step;
      end else begin
        x_q <= x_q - y_sh;
        y_q <= y_q + x_sh;
        z_q <= z_q - step;
      end
      it_q <= it_q + 1'b1;
      if (it_q == IT_W'(ITER-1)) begin
        busy_o <= 1'b0;
        fin_o  <= 1'b1;
      end
    end else begin
      fin_o <= 1'b0;
    end
  end

  assign angle_o = z_q;
endmodule

// File: rtl/cfo_coarse_est.sv
module cfo_coarse_est
  import cfo_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LAG    = 16,
  parameter int WIN    = 32,
  parameter int ACC_W  = 40,
  parameter int ITER   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               valid_i,
  input  logic [DATA_W-1:0]  smp_i_i,
  input  logic [DATA_W-1:0]  smp_q_i,
  output logic [ACC_W-1:0]   corr_re_o,
  output logic [ACC_W-1:0]   corr_im_o,
  output logic [PHASE_W-1:0] incr_o,
  output logic               done_o
);
  localparam int SMP_W  = 2*DATA_W;
  localparam int CNT_W  = $clog2(WIN+1);
  localparam int LAG_SH = $clog2(LAG);  // LAG must be a power of two

  cfo_state_e         state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [SMP_W-1:0]   old_w;
  logic [ACC_W-1:0]   acc_re, acc_im;
  logic [PHASE_W-1:0] angle;
  logic               add_w, win_last, rot_busy, rot_fin, fin_take;

  cfo_lag_line #(.W(SMP_W), .DEPTH(LAG)) u_lag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (valid_i),
    .din_i   ({smp_q_i, smp_i_i}),
    .dout_o  (old_w)
  );

  assign add_w    = valid_i & (start_i | (state_q == ST_ACC));
  assign win_last = !start_i && (state_q == ST_ACC) && valid_i &&
                    (cnt_q == CNT_W'(WIN-1));

  cfo_corr_acc #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (start_i),
    .add_i    (add_w),
    .cur_re_i (smp_i_i),
    .cur_im_i (smp_q_i),
    .old_re_i (old_w[DATA_W-1:0]),
    .old_im_i (old_w[SMP_W-1:DATA_W]),
    .acc_re_o (acc_re),
    .acc_im_o (acc_im)
  );

  cfo_cordic_vec #(.IN_W(ACC_W), .ITER(ITER)) u_rot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (state_q == ST_LOAD),
    .abort_i (start_i),
    .x_i     (acc_re),
    .y_i     (acc_im),
    .angle_o (angle),
    .busy_o  (rot_busy),
    .fin_o   (rot_fin)
  );

  assign fin_take = (state_q == ST_ROT) && rot_fin && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (start_i) begin
      state_q <= ST_ACC;
      cnt_q   <= valid_i ? CNT_W'(1) : '0;
    end else begin
      case (state_q)
        ST_ACC: begin
          if (valid_i) cnt_q <= cnt_q + 1'b1;
          if (win_last) state_q <= ST_LOAD;
        end
        ST_LOAD: state_q <= ST_ROT;
        ST_ROT:  if (rot_fin) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      corr_re_o <= '0;
      corr_im_o <= '0;
      incr_o    <= '0;
    end else begin
      done_o <= fin_take;
      if (fin_take) begin
        corr_re_o <= acc_re;
        corr_im_o <= acc_im;
        incr_o    <= PHASE_W'($signed(angle) >>> LAG_SH);
      end
    end
  end
endmodule

// File: rtl/cfo_coarse_est_chk.sv
module cfo_coarse_est_chk #(
  parameter int DATA_W = 16,
  parameter int WIN    = 32,
  parameter int ACC_W  = 40,
  parameter int ITER   = 16,
  parameter int CNT_W  = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             valid_i,
  input logic             done_o,
  input logic [31:0]      incr_o,
  input logic             win_last_i,
  input logic [ACC_W-1:0] acc_re_i,
  input logic [ACC_W-1:0] acc_im_i,
  input logic [CNT_W-1:0] cnt_i
);
  localparam int SW = $clog2(ITER+4) + 1;

  logic [SW-1:0] since_last;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      since_last <= '1;
    else if (win_last_i)              since_last <= '0;
    else if (since_last != {SW{1'b1}}) since_last <= since_last + 1'b1;
  end

  logic signed [ACC_W:0] bound, are, aim;
  assign bound = (ACC_W+1)'(cnt_i) << (2*DATA_W-1);
  assign are   = $signed({acc_re_i[ACC_W-1], acc_re_i});
  assign aim   = $signed({acc_im_i[ACC_W-1], acc_im_i});

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (since_last == SW'(ITER+2))); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (are <= bound) && (are >= -bound) && (aim <= bound) && (aim >= -bound)); // R9
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !valid_i) |=> (acc_re_i == '0 && acc_im_i == '0 && cnt_i == '0)); // R7
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(incr_o)); // R8
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(WIN)); // R3
endmodule

bind cfo_coarse_est cfo_coarse_est_chk #(
  .DATA_W(DATA_W), .WIN(WIN), .ACC_W(ACC_W), .ITER(ITER), .CNT_W(CNT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .valid_i    (valid_i),
  .done_o     (done_o),
  .incr_o     (incr_o),
  .win_last_i (win_last),
  .acc_re_i   (acc_re),
  .acc_im_i   (acc_im),
  .cnt_i      (cnt_q)
);

// File: tb/cfo_coarse_est_tb_top.sv
`timescale 1ns/1ps
module cfo_coarse_est_tb_top;
  localparam int DATA_W = 16;
  localparam int LAG    = 16;
  localparam int WIN    = 32;
  localparam int ACC_W  = 40;
  localparam int ITER   = 16;
  localparam longint TOL = 2048;
  localparam real AMP = 12000.0;
  localparam real PI  = 3.14159265358979;

  logic clk_i = 1'b0;
  logic rst_ni, start_i, valid_i;
  logic [DATA_W-1:0] smp_i_i, smp_q_i;
  logic [ACC_W-1:0] corr_re_o, corr_im_o;
  logic [31:0] incr_o;
  logic done_o;

  always #10 clk_i = ~clk_i;

  cfo_coarse_est #(.DATA_W(DATA_W), .LAG(LAG), .WIN(WIN), .ACC_W(ACC_W), .ITER(ITER)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .valid_i(valid_i),
    .smp_i_i(smp_i_i), .smp_q_i(smp_q_i), .corr_re_o(corr_re_o),
    .corr_im_o(corr_im_o), .incr_o(incr_o), .done_o(done_o)
  );

  int n_chk = 0, n_err = 0, cyc = 0, dut_dones = 0;
  bit run = 0, finished = 0;
  real ph = 0.0;

  // reference model
  int hq_i[$], hq_q[$];
  longint m_re, m_im, e_re, e_im;
  int m_cnt, m_pend;
  bit m_acc, e_done;
  logic [31:0] prev_incr;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      hq_i.delete(); hq_q.delete();
      m_re = 0; m_im = 0; e_re = 0; e_im = 0;
      m_cnt = 0; m_pend = 0; m_acc = 0; e_done = 0;
    end else begin
      if (start_i) begin
        m_pend = 0; e_done = 0; m_acc = 1; m_cnt = 0; m_re = 0; m_im = 0;
      end else if (m_pend > 0) begin
        m_pend--;
        e_done = (m_pend == 0);
        if (e_done) begin e_re = m_re; e_im = m_im; end
      end else begin
        e_done = 0;
      end
      if (valid_i) begin
        longint a, b, c, d;
        a = longint'($signed(smp_i_i)); b = longint'($signed(smp_q_i));
        c = 0; d = 0;
        if (hq_i.size() == LAG) begin
          c = hq_i.pop_front(); d = hq_q.pop_front();
        end
        hq_i.push_back(int'(a)); hq_q.push_back(int'(b));
        if (m_acc) begin
          m_re += a*c + b*d;
          m_im += b*c - a*d;
          m_cnt++;
          if (m_cnt == WIN) begin m_acc = 0; m_pend = ITER + 2; end
        end
      end
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk_i) begin
    if (run) begin
      check(done_o == e_done, "R6 R7", "done_o", longint'(done_o), longint'(e_done));
      if (done_o) dut_dones++;
      if (e_done) begin
        real ang, w;
        longint ei, diff;
        check(longint'($signed(corr_re_o)) == e_re, "R2 R3 R4 R9", "corr_re", longint'($signed(corr_re_o)), e_re);
        check(longint'($signed(corr_im_o)) == e_im, "R2 R3 R4 R9", "corr_im", longint'($signed(corr_im_o)), e_im);
        ang  = $atan2(real'(e_im), real'(e_re));
        w    = ang / (2.0*PI) * 4294967296.0 / LAG;
        ei   = longint'(w);
        diff = longint'($signed(incr_o)) - ei;
        if (diff < 0) diff = -diff;
        check(diff <= TOL, "R5", "incr_o", longint'($signed(incr_o)), ei);
      end else begin
        check(incr_o == prev_incr, "R8", "incr_o held", longint'(incr_o), longint'(prev_incr));
      end
      prev_incr = incr_o;
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic drive(bit v, bit s, int si, int sq);
    @(negedge clk_i);
    valid_i = v; start_i = s;
    smp_i_i = DATA_W'(si); smp_q_i = DATA_W'(sq);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) drive(0, 0, 0, 0);
  endtask

  task automatic tone(real w, int n, int gap, bit st);
    for (int k = 0; k < n; k++) begin
      drive(1, st && k == 0, int'(AMP*$cos(ph)), int'(AMP*$sin(ph)));
      ph += w / LAG;
      for (int g = 0; g < gap; g++) drive(0, 0, 0, 0);
    end
  endtask

  initial begin
    int d0;
    rst_ni = 0; start_i = 0; valid_i = 0; smp_i_i = '0; smp_q_i = '0;
    prev_incr = '0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(done_o == 1'b0, "R1", "done_o in reset", longint'(done_o), 0);
    check(corr_re_o == '0 && corr_im_o == '0, "R1", "corr in reset", longint'(corr_re_o), 0);
    check(incr_o == '0, "R1", "incr_o in reset", longint'(incr_o), 0);
    rst_ni = 1;
    run = 1;

    // T1: partly empty history after reset (R2), +0.3 rad/lag, extra samples (R8)
    tone(0.3, 8, 0, 0);
    drive(0, 1, 0, 0);
    tone(0.3, 44, 0, 0);
    idle(30);

    // T2: gaps between strobes, start with valid (R3 R4), -1.0 rad
    tone(-1.0, 16, 1, 0);
    tone(-1.0, 32, 1, 1);
    idle(30);

    // T3: left half-plane, +2.5 rad; samples after the window (R8)
    tone(2.5, 16, 0, 0);
    tone(2.5, 32, 0, 1);
    tone(2.5, 20, 0, 0);
    idle(10);

    // T4: third quadrant, -2.8 rad (R5)
    tone(-2.8, 16, 0, 0);
    tone(-2.8, 32, 0, 1);
    idle(30);

    // T5: restart during accumulation (R7)
    tone(0.7, 16, 0, 0);
    tone(0.7, 10, 0, 1);
    tone(0.7, 32, 0, 1);
    idle(30);

    // T6: restart during angle computation (R7)
    d0 = dut_dones;
    tone(-0.5, 16, 0, 0);
    tone(-0.5, 32, 0, 1);
    idle(5);
    tone(-0.5, 32, 0, 1);
    idle(30);
    check(dut_dones - d0 == 1, "R7", "done count after abort", longint'(dut_dones - d0), 1);

    // T7: full-scale negative samples (R9), angle zero
    for (int k = 0; k < 16; k++) drive(1, 0, -32768, -32768);
    for (int k = 0; k < 32; k++) drive(1, k == 0, -32768, -32768);
    idle(30);
    check(longint'($signed(corr_re_o)) == (longint'(1) << 36), "R9", "full-scale sum",
          longint'($signed(corr_re_o)), longint'(1) << 36);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule